// File: doc/BRIEF.md
# Associative Page Frame Translator

This block translates effective word addresses for a demand-paged store in which each physical page frame owns one register. A register names the effective page currently resident in its frame, plus a valid flag and a usage flag. Each access splits the effective address into a page number and a word offset. The page number is compared against every frame register in the same cycle. On a match, the frame number replaces the page number to form the physical address, and the access may proceed. Without a match, the block raises a fault, and the access must not complete.

Faults are serviced through a two-step handshake. A service request makes the block choose a frame and report it, together with that frame's previous page number and valid flag. An empty frame is taken first. If there is none, the lowest frame that has not been used since the last sweep is taken. If every frame has been used, all usage flags are cleared and frame 0 is taken. Once the external transfer has finished, a load pulse writes the new page number into the chosen frame.

Top module: `pagereg_xlate`

## Requirements
- R1: After reset every frame is invalid, so any access, including one to page 0, gives fault=1 and hit=0.
- R2: When acc_valid is high and a valid frame holds acc_addr[EA_W-1:OFF_W], hit=1 in the same cycle, frame_idx gives that frame, and phys_addr = {frame_idx, acc_addr[OFF_W-1:0]}, with OFF_W = 9 (512-word pages).
- R3: When acc_valid is high and no valid frame holds the page, fault=1 and hit=0.
- R4: When acc_valid is low, hit, fault and multi_match are 0, and no usage flag is set.
- R5: A hit sets the usage flag of the reported frame at the next clock edge.
- R6: On svc_req, if an invalid frame exists, the lowest-numbered one is reported on victim_frame from the next cycle, with victim_kind = 0.
- R7: On svc_req with all frames valid, the lowest-numbered frame whose usage flag is clear is reported, with victim_kind = 1.
- R8: On svc_req with all frames valid and all usage flags set, every usage flag is cleared and frame 0 is reported, with victim_kind = 2.
- R9: Together with the victim, victim_old_pn and victim_old_valid report that frame's contents before the request.
- R10: A load_done pulse writes load_pn into the last reported victim frame, sets its valid flag and clears its usage flag. The load takes priority over a hit to the same frame in the same cycle.
- R11: If more than one valid frame holds the accessed page, multi_match=1, hit=1, and the lowest-numbered matching frame is reported.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_valid | input | 1 | An access is presented |
| acc_addr | input | EA_W | Effective word address |
| hit | output | 1 | Page is resident |
| fault | output | 1 | Page is not resident; the access must not complete |
| multi_match | output | 1 | More than one frame holds the page |
| frame_idx | output | log2(FRAMES) | Frame that holds the page |
| phys_addr | output | log2(FRAMES)+OFF_W | Translated address |
| svc_req | input | 1 | Pulse: choose a frame to refill |
| victim_frame | output | log2(FRAMES) | Chosen frame |
| victim_kind | output | 2 | 0 empty frame, 1 unused frame, 2 after a sweep |
| victim_old_pn | output | EA_W-OFF_W | Page previously held by the chosen frame |
| victim_old_valid | output | 1 | Chosen frame was valid before the request |
| load_done | input | 1 | Pulse: transfer finished, write the frame |
| load_pn | input | EA_W-OFF_W | Page number to write |

## Verification
The hardest state to reach from the ports is a table in which every frame is valid and every usage flag is set, which is the only case that triggers the sweep. The bench reaches it deterministically. It fills all 32 frames through the service handshake and then hits each page once. It then reloads a page that is already present, which creates the duplicate entry needed for the multi-match case. A randomized phase over a small page range follows. Because that range is small, hits, faults, duplicates and repeated sweeps keep recurring.

// File: rtl/pagereg_pkg.sv
package pagereg_pkg;
  typedef enum logic [1:0] {
    VK_FREE   = 2'd0,
    VK_UNUSED = 2'd1,
    VK_SWEEP  = 2'd2
  } vkind_e;
endpackage

// File: rtl/pagereg_match.sv
module pagereg_match #(
  parameter int N     = 32,
  parameter int PN_W  = 11,
  parameter int IDX_W = $clog2(N)
) (
  input  logic [PN_W-1:0]  pn_tab [N],
  input  logic [N-1:0]     valid_vec,
  input  logic [PN_W-1:0]  key,
  output logic [N-1:0]     match_vec,
  output logic [IDX_W-1:0] first_idx,
  output logic             any_match,
  output logic             many_match
);
  // index of lowest set bit, 0 when none
  function automatic logic [IDX_W-1:0] lowest_set(input logic [N-1:0] v);
    logic [IDX_W-1:0] r;
    r = '0;
    for (int i = N - 1; i >= 0; i--)
      if (v[i]) r = IDX_W'(i);
    return r;
  endfunction

  function automatic int ones(input logic [N-1:0] v);
    int c;
    c = 0;
    for (int i = 0; i < N; i++) c += int'(v[i]);
    return c;
  endfunction

  for (genvar g = 0; g < N; g++) begin : g_cmp
    assign match_vec[g] = valid_vec[g] && (pn_tab[g] == key);
  end

  assign first_idx  = lowest_set(match_vec);
  assign any_match  = |match_vec;
  assign many_match = ones(match_vec) > 1;
endmodule

// File: rtl/pagereg_victim.sv
module pagereg_victim
  import pagereg_pkg::*;
#(
  parameter int N     = 32,
  parameter int IDX_W = $clog2(N)
) (
  input  logic [N-1:0]     valid_vec,
  input  logic [N-1:0]     used_vec,
  output logic [IDX_W-1:0] pick_idx,
  output vkind_e           pick_kind,
  output logic             sweep
);
  function automatic logic [IDX_W-1:0] lowest_set(input logic [N-1:0] v);
    logic [IDX_W-1:0] r;
    r = '0;
    for (int i = N - 1; i >= 0; i--)
      if (v[i]) r = IDX_W'(i);
    return r;
  endfunction

  logic [N-1:0] empty_vec, cold_vec;
  assign empty_vec = ~valid_vec;
  assign cold_vec  = ~used_vec;

  always_comb begin
    sweep = 1'b0;
    if (|empty_vec) begin
      pick_idx  = lowest_set(empty_vec);
      pick_kind = VK_FREE;
    end else if (|cold_vec) begin
      pick_idx  = lowest_set(cold_vec);
      pick_kind = VK_UNUSED;
    end else begin
      pick_idx  = '0;
      pick_kind = VK_SWEEP;
      sweep     = 1'b1;
    end
  end
endmodule

// File: rtl/pagereg_xlate.sv
module pagereg_xlate
  import pagereg_pkg::*;
#(
  parameter int FRAMES = 32,
  parameter int EA_W   = 20,
  parameter int OFF_W  = 9,
  localparam int PN_W  = EA_W - OFF_W,
  localparam int IDX_W = $clog2(FRAMES)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   acc_valid,
  input  logic [EA_W-1:0]        acc_addr,
  output logic                   hit,
  output logic                   fault,
  output logic                   multi_match,
  output logic [IDX_W-1:0]       frame_idx,
  output logic [IDX_W+OFF_W-1:0] phys_addr,
  input  logic                   svc_req,
  output logic [IDX_W-1:0]       victim_frame,
  output logic [1:0]             victim_kind,
  output logic [PN_W-1:0]        victim_old_pn,
  output logic                   victim_old_valid,
  input  logic                   load_done,
  input  logic [PN_W-1:0]        load_pn
);
  logic [PN_W-1:0]   pn_q [FRAMES];
  logic [FRAMES-1:0] valid_vec, used_vec;

  // named internal events
  logic [FRAMES-1:0] match_vec;
  logic [IDX_W-1:0]  first_idx, pick_idx;
  logic              any_match, many_match, sweep_ev, hit_ev;
  vkind_e            pick_kind;

  pagereg_match #(.N(FRAMES), .PN_W(PN_W), .IDX_W(IDX_W)) u_match (
    .pn_tab    (pn_q),
    .valid_vec (valid_vec),
    .key       (acc_addr[EA_W-1:OFF_W]),
    .match_vec (match_vec),
    .first_idx (first_idx),
    .any_match (any_match),
    .many_match(many_match)
  );

  pagereg_victim #(.N(FRAMES), .IDX_W(IDX_W)) u_victim (
    .valid_vec(valid_vec),
    .used_vec (used_vec),
    .pick_idx (pick_idx),
    .pick_kind(pick_kind),
    .sweep    (sweep_ev)
  );

  assign hit_ev      = acc_valid && any_match;
  assign hit         = hit_ev;
  assign fault       = acc_valid && !any_match;
  assign multi_match = acc_valid && many_match;
  assign frame_idx   = first_idx;
  assign phys_addr   = {first_idx, acc_addr[OFF_W-1:0]};

  // next usage vector: sweep clear, then hit set, then load clear
  logic [FRAMES-1:0] used_nxt;
  always_comb begin
    used_nxt = used_vec;
    if (svc_req && sweep_ev) used_nxt = '0;
    if (hit_ev) used_nxt[first_idx] = 1'b1;
    if (load_done) used_nxt[victim_frame] = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_vec <= '0;
      used_vec  <= '0;
      for (int i = 0; i < FRAMES; i++) pn_q[i] <= '0;
    end else begin
      used_vec <= used_nxt;
      if (load_done) begin
        valid_vec[victim_frame] <= 1'b1;
        pn_q[victim_frame]      <= load_pn;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      victim_frame     <= '0;
      victim_kind      <= VK_FREE;
      victim_old_pn    <= '0;
      victim_old_valid <= 1'b0;
    end else if (svc_req) begin
      victim_frame     <= pick_idx;
      victim_kind      <= pick_kind;
      victim_old_pn    <= pn_q[pick_idx];
      victim_old_valid <= valid_vec[pick_idx];
    end
  end
endmodule

// File: rtl/pagereg_xlate_chk.sv
module pagereg_xlate_chk #(
  parameter int FRAMES = 32,
  parameter int EA_W   = 20,
  parameter int OFF_W  = 9,
  localparam int IDX_W = $clog2(FRAMES)
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   acc_valid,
  input logic [EA_W-1:0]        acc_addr,
  input logic                   hit,
  input logic                   fault,
  input logic                   multi_match,
  input logic [IDX_W-1:0]       frame_idx,
  input logic [IDX_W+OFF_W-1:0] phys_addr,
  input logic                   svc_req,
  input logic                   load_done,
  input logic [IDX_W-1:0]       victim_frame,
  input logic [1:0]             victim_kind,
  input logic [FRAMES-1:0]      match_vec,
  input logic [FRAMES-1:0]      valid_vec,
  input logic                   sweep_ev
);
  p_excl_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !(hit && fault));
  p_fault_r3: assert property (@(posedge clk) disable iff (!rst_n)
    fault |-> (match_vec == '0));
  p_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_valid |-> (!hit && !fault && !multi_match));
  p_hitframe_r2: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> match_vec[frame_idx]);
  p_offset_r2: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> (phys_addr[OFF_W-1:0] == acc_addr[OFF_W-1:0]));
  p_multi_r11: assert property (@(posedge clk) disable iff (!rst_n)
    multi_match |-> hit);
  p_sweep_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (svc_req && sweep_ev) |=> (victim_frame == '0 && victim_kind == 2'd2));
  p_load_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (load_done && !svc_req) |=> valid_vec[$past(victim_frame)]);
endmodule

bind pagereg_xlate pagereg_xlate_chk #(
  .FRAMES(FRAMES), .EA_W(EA_W), .OFF_W(OFF_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_addr(acc_addr),
  .hit(hit), .fault(fault), .multi_match(multi_match),
  .frame_idx(frame_idx), .phys_addr(phys_addr), .svc_req(svc_req),
  .load_done(load_done), .victim_frame(victim_frame),
  .victim_kind(victim_kind), .match_vec(match_vec),
  .valid_vec(valid_vec), .sweep_ev(sweep_ev)
);

// File: tb/test_pagereg_xlate.sv
module test_pagereg_xlate;
  localparam int N = 32, EA_W = 20, OFF_W = 9, PN_W = EA_W - OFF_W, IDX_W = 5;

  logic clk = 1'b0, rst_n = 1'b0;
  logic acc_valid = 1'b0, svc_req = 1'b0, load_done = 1'b0;
  logic [EA_W-1:0] acc_addr = '0;
  logic [PN_W-1:0] load_pn = '0;
  logic hit, fault, multi_match, victim_old_valid;
  logic [IDX_W-1:0] frame_idx, victim_frame;
  logic [IDX_W+OFF_W-1:0] phys_addr;
  logic [1:0] victim_kind;
  logic [PN_W-1:0] victim_old_pn;

  pagereg_xlate i_pagereg_xlate (.*);

  always #10 clk = ~clk;

  int checks = 0, errs = 0;
  logic [PN_W-1:0] m_pn [N];
  logic [N-1:0] m_v = '0, m_u = '0;
  int m_vic = 0;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int b_first(input logic [PN_W-1:0] p);
    for (int i = 0; i < N; i++) if (m_v[i] && m_pn[i] == p) return i;
    return -1;
  endfunction

  function automatic int b_count(input logic [PN_W-1:0] p);
    int c = 0;
    for (int i = 0; i < N; i++) if (m_v[i] && m_pn[i] == p) c++;
    return c;
  endfunction

  // returns frame; kind via output
  function automatic int b_victim(output int kind);
    for (int i = 0; i < N; i++) if (!m_v[i]) begin kind = 0; return i; end
    for (int i = 0; i < N; i++) if (!m_u[i]) begin kind = 1; return i; end
    kind = 2;
    return 0;
  endfunction

  task automatic do_access(input bit v, input logic [PN_W-1:0] p, input logic [OFF_W-1:0] off);
    int f, c;
    @(negedge clk);
    acc_valid = v;
    acc_addr = {p, off};
    #1;
    f = b_first(p);
    c = b_count(p);
    if (!v) begin
      chk(!hit && !fault && !multi_match, "R4", {hit, fault, multi_match}, 0);
    end else if (f < 0) begin
      chk(fault && !hit, "R3", {hit, fault}, 1);
    end else begin
      chk(hit && !fault, "R2 hit", {hit, fault}, 2);
      chk(frame_idx == f, c > 1 ? "R11 frame" : "R2 frame", frame_idx, f);
      chk(phys_addr == {f[IDX_W-1:0], off}, "R2 phys", phys_addr, {f[IDX_W-1:0], off});
      chk(multi_match == (c > 1), "R11 multi", multi_match, c > 1);
    end
    @(posedge clk);
    if (v && f >= 0) m_u[f] = 1'b1;  // R5
    @(negedge clk);
    acc_valid = 1'b0;
  endtask

  task automatic do_svc(input string req);
    int k, f;
    logic [PN_W-1:0] op;
    logic ov;
    @(negedge clk);
    svc_req = 1'b1;
    f = b_victim(k);
    op = m_pn[f];
    ov = m_v[f];
    @(posedge clk);
    if (k == 2) m_u = '0;
    m_vic = f;
    @(negedge clk);
    svc_req = 1'b0;
    #1;
    chk(victim_frame == f, req, victim_frame, f);
    chk(victim_kind == k, req, victim_kind, k);
    chk(victim_old_valid == ov && (!ov || victim_old_pn == op), "R9",
        victim_old_pn, op);
  endtask

  task automatic do_load(input logic [PN_W-1:0] p);
    @(negedge clk);
    load_done = 1'b1;
    load_pn = p;
    @(posedge clk);
    m_pn[m_vic] = p;
    m_v[m_vic] = 1'b1;
    m_u[m_vic] = 1'b0;
    @(negedge clk);
    load_done = 1'b0;
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  endtask

  initial begin
    #(20 * 190000);
    checks++;
    errs++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < N; i++) m_pn[i] = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    // R1: nothing resident after reset, page 0 included
    @(negedge clk);
    acc_valid = 1'b1;
    acc_addr = '0;
    #1;
    chk(fault && !hit, "R1", {hit, fault}, 1);
    acc_valid = 1'b0;
    // R6 fill every frame
    for (int i = 0; i < N; i++) begin
      do_svc("R6");
      do_load(PN_W'(100 + i));
    end
    // R2 R5 hit each page
    for (int i = 0; i < N; i++) do_access(1'b1, PN_W'(100 + i), OFF_W'($urandom));
    do_access(1'b1, PN_W'(7), 9'h1ff);     // R3 miss
    do_svc("R8");                          // all used: sweep, frame 0
    do_load(PN_W'(105));                   // duplicate of frame 5
    do_access(1'b1, PN_W'(105), 9'h003);   // R11 lowest wins
    do_svc("R7");                          // frame 1
    do_load(PN_W'(200));
    do_access(1'b0, PN_W'(200), 9'h000);   // R4 idle
    do_svc("R7 R4 no used set");           // frame 1 again
    do_load(PN_W'(201));
    // R10 load wins over same-cycle hit on the victim frame
    do_svc("R7");                          // frame 1
    @(negedge clk);
    acc_valid = 1'b1;
    acc_addr = {PN_W'(201), 9'h010};
    load_done = 1'b1;
    load_pn = PN_W'(202);
    @(posedge clk);
    m_pn[1] = PN_W'(202);
    m_u[1] = 1'b0;
    @(negedge clk);
    acc_valid = 1'b0;
    load_done = 1'b0;
    do_access(1'b1, PN_W'(202), 9'h021);   // R10 new page resident
    do_access(1'b1, PN_W'(201), 9'h021);   // R10 old page gone
    // random phase
    for (int it = 0; it < 3000; it++) begin
      int r = $urandom % 10;
      if (r < 7) do_access(($urandom % 8) != 0, PN_W'(95 + $urandom % 48), OFF_W'($urandom));
      else begin
        do_svc("R6 R7 R8 random");
        do_load(PN_W'(95 + $urandom % 48));
      end
    end
    finish_run();
  end
endmodule